// File: doc/BRIEF.md
# Sequencer Host Register Bank

This block is the 32-bit register bank that a host uses to load and control a pulse sequencer. It holds a scratch register and a control/status word that mixes writable control bits with live sequencer status. It also holds the program address, four 32-bit staging registers that together form one 128-bit program word, and three fixed identity words. The bus is synchronous and simple: a byte offset, a write enable, write data, and read data that is decoded combinationally from the offset.

The program word is loaded one quarter at a time. Writing the highest quarter commits all 128 bits to program memory at the current program address, using a single-cycle write strobe. The control word produces start and stop pulses for the sequencer. It selects between a host-triggered start and an external start input. In test mode it replaces the sequencer's 32 outputs with the program address.

Top module: `seq_host_regs`

## Requirements
- R1: The scratch register at offset 0x00 reads back exactly the last 32-bit value written to it.
- R2: Reads of offsets 0x20 and of any offset above 0x28 return zero. Writes to offsets 0x1C, 0x20, 0x24 and 0x28 leave every register unchanged.
- R3: The control/status word is at offset 0x04. Bit 1 drives `ext_clk_o`, bit 2 drives `ext_start_en_o`, bit 3 drives `slow_clk_o` and bit 4 drives `test_mode_o`; these four bits are stored on write. Bits 31:5 read as {delay[6:0], sp[7:0], pc[11:0]} taken live from the status inputs, and writes to them are discarded.
- R4: Control/status bit 0 reads as `seq_running_i`, whatever was written to it.
- R5: A write to offset 0x04 with bit 0 = 1 and bit 2 = 0 raises `start_o` for exactly one cycle, in the cycle after the write.
- R6: A write to offset 0x04 with bit 2 = 1 raises no start. While the stored bit 2 is 1, a rising edge on `ext_start_i` raises `start_o` for one cycle, in the cycle after the edge is sampled. While bit 2 is 0, the edge has no effect.
- R7: A write to offset 0x04 with bit 0 = 0 while `seq_running_i` is 1 raises `stop_o` for one cycle after the write. The same write while the sequencer is idle raises no stop.
- R8: The program address at offset 0x08 keeps the low 12 bits of the written value, and the upper bits read as zero. The staging quarters at 0x0C, 0x10, 0x14 and 0x18 (lowest to highest) read back their written values.
- R9: A write to offset 0x18 raises `mem_we_o` for one cycle after the write. In that cycle `mem_addr_o` holds the program address and `mem_data_o` holds {written value, quarter 0x14, quarter 0x10, quarter 0x0C}. Writes to the other three quarters raise no strobe.
- R10: While test mode is set, `out_o` equals the zero-extended program address. Otherwise it equals `seq_out_i`.
- R11: Offsets 0x1C, 0x24 and 0x28 return the build-timestamp, serial and hardware-identity parameters.
- R12: After reset, all stored registers are zero and `start_o`, `stop_o` and `mem_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wr_i | input | 1 | Write enable |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| seq_running_i | input | 1 | Sequencer is executing |
| seq_pc_i | input | 12 | Sequencer program counter |
| seq_sp_i | input | 8 | Sequencer stack pointer |
| seq_delay_i | input | 32 | Sequencer delay counter |
| seq_out_i | input | 32 | Sequencer pattern outputs |
| ext_start_i | input | 1 | External start input |
| start_o | output | 1 | One-cycle start request |
| stop_o | output | 1 | One-cycle stop request |
| ext_clk_o | output | 1 | External clock select |
| ext_start_en_o | output | 1 | External start enabled |
| slow_clk_o | output | 1 | Slow clock select |
| test_mode_o | output | 1 | Test mode active |
| out_o | output | 32 | Pattern outputs after test-mode mux |
| mem_we_o | output | 1 | Program memory write strobe |
| mem_addr_o | output | 12 | Program memory write address |
| mem_data_o | output | 128 | Program memory write word |

## Verification
The scratch register is written with alternating and all-ones patterns, so a stuck or swapped bit shows up. Each staging quarter gets a distinct constant, so the committed 128-bit word shows whether the quarters are misordered and whether a lower-quarter write strobes memory by mistake. Control writes set bit 0 with bit 2 clear and with bit 2 set, and are made with the sequencer running and idle. These cases separate host start from external start and a real stop from a harmless clear. The status inputs carry a distinct value in each field, so the pc, sp and delay slices can be told apart on readback.

// File: rtl/seq_host_pkg.sv
package seq_host_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned QUARTERS = 4;

  typedef enum logic [3:0] {
    RG_TEST  = 4'd0,
    RG_CSR   = 4'd1,
    RG_ADDR  = 4'd2,
    RG_Q0    = 4'd3,
    RG_Q1    = 4'd4,
    RG_Q2    = 4'd5,
    RG_Q3    = 4'd6,
    RG_VER   = 4'd7,
    RG_FLASH = 4'd8,
    RG_SER   = 4'd9,
    RG_HW    = 4'd10
  } reg_idx_e;

  localparam int unsigned CSR_RUN      = 0;
  localparam int unsigned CSR_XCLK     = 1;
  localparam int unsigned CSR_XSTART   = 2;
  localparam int unsigned CSR_SLOW     = 3;
  localparam int unsigned CSR_TMODE    = 4;
  localparam int unsigned CSR_STAT_LSB = 5;
endpackage

// File: rtl/seq_host_csr.sv
module seq_host_csr
  import seq_host_pkg::*;
#(
  parameter int unsigned PC_W = 12,
  parameter int unsigned SP_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            running_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [SP_W-1:0] sp_i,
  input  logic [DW-1:0]   delay_i,
  input  logic            ext_start_i,
  output logic [DW-1:0]   rdata_o,
  output logic            start_o,
  output logic            stop_o,
  output logic            ext_clk_o,
  output logic            ext_start_en_o,
  output logic            slow_clk_o,
  output logic            test_mode_o
);
  localparam int unsigned STAT_W = DW - CSR_STAT_LSB;
  localparam int unsigned DLY_W  = STAT_W - PC_W - SP_W;
  localparam int unsigned CTRL_W = CSR_TMODE - CSR_XCLK + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic              ext_prev_q;
  logic              start_q;
  logic              stop_q;
  logic              ext_edge;
  logic              host_start;
  logic [STAT_W-1:0] status;

  assign ext_edge   = ctrl_q[CSR_XSTART-CSR_XCLK] & ext_start_i & ~ext_prev_q;
  assign host_start = wr_i & wdata_i[CSR_RUN] & ~wdata_i[CSR_XSTART];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      ext_prev_q <= 1'b0;
      start_q    <= 1'b0;
      stop_q     <= 1'b0;
    end else begin
      ext_prev_q <= ext_start_i;
      start_q    <= ext_edge | host_start;
      stop_q     <= wr_i & ~wdata_i[CSR_RUN] & running_i;
      if (wr_i) ctrl_q <= wdata_i[CSR_TMODE:CSR_XCLK];
    end
  end

  // status is sampled live; no storage for the read-only field
  assign status  = {delay_i[DLY_W-1:0], sp_i, pc_i};
  assign rdata_o = {status, ctrl_q, running_i};

  assign start_o        = start_q;
  assign stop_o         = stop_q;
  assign ext_clk_o      = ctrl_q[CSR_XCLK-CSR_XCLK];
  assign ext_start_en_o = ctrl_q[CSR_XSTART-CSR_XCLK];
  assign slow_clk_o     = ctrl_q[CSR_SLOW-CSR_XCLK];
  assign test_mode_o    = ctrl_q[CSR_TMODE-CSR_XCLK];

  // R6
  ext_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[CSR_XSTART] && !ext_edge) |=> !start_o);

  // R7
  stop_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> $past(running_i));

  // R5
  start_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(wr_i || ext_start_i));
endmodule

// File: rtl/seq_host_stage.sv
module seq_host_stage
  import seq_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [QSW-1:0]         sel_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [QUARTERS*DW-1:0] mem_data_o
);
  localparam int unsigned QSW    = $clog2(QUARTERS);
  localparam int unsigned WORD_W = QUARTERS * DW;
  localparam logic [QSW-1:0] TOP = QSW'(QUARTERS - 1);

  logic [DW-1:0]     qtr_q [QUARTERS];
  logic [WORD_W-1:0] commit_word;
  logic              top_wr;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;

  assign top_wr = wr_i && (sel_i == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int q = 0; q < QUARTERS; q++) qtr_q[q] <= '0;
    end else if (wr_i) begin
      qtr_q[sel_i] <= wdata_i;
    end
  end

  // top quarter comes straight from the bus so commit is atomic with its write
  for (genvar q = 0; q < QUARTERS; q++) begin : g_word
    if (q == QUARTERS - 1) begin : g_top
      assign commit_word[q*DW +: DW] = wdata_i;
    end else begin : g_low
      assign commit_word[q*DW +: DW] = qtr_q[q];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= top_wr;
      if (top_wr) begin
        addr_q <= addr_i;
        data_q <= commit_word;
      end
    end
  end

  assign rdata_o    = qtr_q[sel_i];
  assign mem_we_o   = we_q;
  assign mem_addr_o = addr_q;
  assign mem_data_o = data_q;

  // R9
  commit_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_wr |=> (mem_we_o && mem_data_o[WORD_W-1 -: DW] == $past(wdata_i)
                && mem_addr_o == $past(addr_i)));

  // R9
  commit_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i != TOP) |=> !mem_we_o);
endmodule

// File: rtl/seq_host_regs.sv
module seq_host_regs
  import seq_host_pkg::*;
#(
  parameter int unsigned BUS_AW  = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned PC_W    = 12,
  parameter int unsigned SP_W    = 8,
  parameter logic [31:0] BUILD_TS = 32'h4CD8_7A00,
  parameter logic [31:0] SERIAL   = 32'h0000_0007,
  parameter logic [31:0] HW_ID    = 32'h5053_4551
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [BUS_AW-1:0]      bus_addr_i,
  input  logic                   bus_wr_i,
  input  logic [31:0]            bus_wdata_i,
  output logic [31:0]            bus_rdata_o,
  input  logic                   seq_running_i,
  input  logic [PC_W-1:0]        seq_pc_i,
  input  logic [SP_W-1:0]        seq_sp_i,
  input  logic [31:0]            seq_delay_i,
  input  logic [31:0]            seq_out_i,
  input  logic                   ext_start_i,
  output logic                   start_o,
  output logic                   stop_o,
  output logic                   ext_clk_o,
  output logic                   ext_start_en_o,
  output logic                   slow_clk_o,
  output logic                   test_mode_o,
  output logic [31:0]            out_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [QUARTERS*32-1:0] mem_data_o
);
  localparam int unsigned WIDX_W = BUS_AW - 2;
  localparam int unsigned QSW    = $clog2(QUARTERS);

  logic [WIDX_W-1:0] widx;
  logic              hit;
  reg_idx_e          sel;
  logic              is_qtr;
  logic [QSW-1:0]    qsel;
  logic [DW-1:0]     test_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     addr_ext;
  logic [DW-1:0]     csr_rdata;
  logic [DW-1:0]     qtr_rdata;

  assign widx   = bus_addr_i[BUS_AW-1:2];
  assign hit    = widx <= WIDX_W'(RG_HW);
  assign sel    = reg_idx_e'(widx[3:0]);
  assign is_qtr = hit && (sel >= RG_Q0) && (sel <= RG_Q3);
  assign qsel   = QSW'(widx[3:0] - 4'(RG_Q0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_q <= '0;
      addr_q <= '0;
    end else if (bus_wr_i && hit) begin
      if (sel == RG_TEST) test_q <= bus_wdata_i;
      if (sel == RG_ADDR) addr_q <= bus_wdata_i[ADDR_W-1:0];
    end
  end

  assign addr_ext = {{(DW-ADDR_W){1'b0}}, addr_q};

  seq_host_csr #(.PC_W(PC_W), .SP_W(SP_W)) csr_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_i           (bus_wr_i && hit && sel == RG_CSR),
    .wdata_i        (bus_wdata_i),
    .running_i      (seq_running_i),
    .pc_i           (seq_pc_i),
    .sp_i           (seq_sp_i),
    .delay_i        (seq_delay_i),
    .ext_start_i    (ext_start_i),
    .rdata_o        (csr_rdata),
    .start_o        (start_o),
    .stop_o         (stop_o),
    .ext_clk_o      (ext_clk_o),
    .ext_start_en_o (ext_start_en_o),
    .slow_clk_o     (slow_clk_o),
    .test_mode_o    (test_mode_o)
  );

  seq_host_stage #(.ADDR_W(ADDR_W)) stage_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bus_wr_i && is_qtr),
    .sel_i      (qsel),
    .wdata_i    (bus_wdata_i),
    .addr_i     (addr_q),
    .rdata_o    (qtr_rdata),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_data_o (mem_data_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (hit) begin
      unique case (sel)
        RG_TEST:                  bus_rdata_o = test_q;
        RG_CSR:                   bus_rdata_o = csr_rdata;
        RG_ADDR:                  bus_rdata_o = addr_ext;
        RG_Q0, RG_Q1, RG_Q2, RG_Q3: bus_rdata_o = qtr_rdata;
        RG_VER:                   bus_rdata_o = BUILD_TS;
        RG_SER:                   bus_rdata_o = SERIAL;
        RG_HW:                    bus_rdata_o = HW_ID;
        default:                  bus_rdata_o = '0;
      endcase
    end
  end

  assign out_o = test_mode_o ? addr_ext : seq_out_i;

  // R10
  mirror_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_o |-> out_o[DW-1:ADDR_W] == '0);

  // R8
  commit_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o == $past(addr_q));
endmodule

// File: tb/seq_host_regs_tb.sv
module seq_host_regs_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         running = 1'b0;
  logic [11:0]  pc = '0;
  logic [7:0]   sp = '0;
  logic [31:0]  dly = '0;
  logic [31:0]  seq_out = '0;
  logic         ext_start = 1'b0;
  logic         start, stop, ext_clk, ext_en, slow_clk, tmode;
  logic [31:0]  out;
  logic         mem_we;
  logic [11:0]  mem_addr;
  logic [127:0] mem_data;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [31:0] TS = 32'h4CD8_7A00;
  localparam logic [31:0] SN = 32'h0000_0007;
  localparam logic [31:0] HW = 32'h5053_4551;

  always #10 clk = ~clk;

  seq_host_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .seq_running_i(running), .seq_pc_i(pc), .seq_sp_i(sp), .seq_delay_i(dly),
    .seq_out_i(seq_out), .ext_start_i(ext_start),
    .start_o(start), .stop_o(stop), .ext_clk_o(ext_clk), .ext_start_en_o(ext_en),
    .slow_clk_o(slow_clk), .test_mode_o(tmode), .out_o(out),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write spans one rising edge; returns at the following falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R12 test reg", d, 0);
    rd(8'h04, d); chk("R12 csr", d, 0);
    rd(8'h08, d); chk("R12 addr", d, 0);
    chk("R12 strobes", {start, stop, mem_we, tmode}, 0);
  endtask

  task automatic t_scratch();
    logic [31:0] d;
    wr(8'h00, 32'hA5A5_5A5A); rd(8'h00, d); chk("R1 pattern", d, 32'hA5A5_5A5A);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R1 ones", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    wr(8'h1C, 32'h1111_1111); wr(8'h20, 32'h2222_2222);
    wr(8'h24, 32'h3333_3333); wr(8'h28, 32'h4444_4444);
    rd(8'h1C, d); chk("R11 timestamp", d, TS);
    rd(8'h24, d); chk("R11 serial", d, SN);
    rd(8'h28, d); chk("R11 hw id", d, HW);
    rd(8'h20, d); chk("R2 reserved", d, 0);
    rd(8'h2C, d); chk("R2 unmapped 0x2C", d, 0);
    rd(8'hFC, d); chk("R2 unmapped 0xFC", d, 0);
    rd(8'h00, d); chk("R2 scratch untouched", d, 32'hFFFF_FFFF);
    chk("R2 no side effect", {start, stop, mem_we, tmode, ext_en}, 0);
  endtask

  task automatic t_csr();
    logic [31:0] d;
    pc = 12'hABC; sp = 8'h5A; dly = 32'h1234_56FF;
    wr(8'h04, 32'hFFFF_FFFE);
    chk("R3 ctrl outs", {ext_clk, ext_en, slow_clk, tmode}, 4'hF);
    rd(8'h04, d); chk("R3 status", d, {7'h7F, 8'h5A, 12'hABC, 4'hF, 1'b0});
    pc = 12'h001;
    rd(8'h04, d); chk("R3 live pc", d, {7'h7F, 8'h5A, 12'h001, 4'hF, 1'b0});
    running = 1'b1;
    rd(8'h04, d); chk("R4 run reads state", d[0], 1'b1);
    running = 1'b0;
    wr(8'h04, 32'h0); pc = '0; sp = '0; dly = '0;
    rd(8'h04, d); chk("R3 cleared", d, 0);
  endtask

  task automatic t_start();
    wr(8'h04, 32'h1);
    chk("R5 start pulse", start, 1'b1);
    @(negedge clk); chk("R5 start one cycle", start, 1'b0);
  endtask

  task automatic t_ext();
    wr(8'h04, 32'h5);
    chk("R6 csr run gated", start, 1'b0);
    @(negedge clk); ext_start = 1'b1;
    @(negedge clk); chk("R6 ext edge start", start, 1'b1);
    @(negedge clk); chk("R6 ext level no repeat", start, 1'b0);
    ext_start = 1'b0;
    wr(8'h04, 32'h0);
    @(negedge clk); ext_start = 1'b1;
    @(negedge clk); chk("R6 ext ignored when off", start, 1'b0);
    ext_start = 1'b0;
  endtask

  task automatic t_stop();
    running = 1'b1;
    wr(8'h04, 32'h0);
    chk("R7 stop pulse", stop, 1'b1);
    @(negedge clk); chk("R7 stop one cycle", stop, 1'b0);
    running = 1'b0;
    wr(8'h04, 32'h0);
    chk("R7 no stop idle", stop, 1'b0);
  endtask

  task automatic t_stage();
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_F123);
    rd(8'h08, d); chk("R8 addr masked", d, 32'h0000_0123);
    wr(8'h0C, 32'h1111_1111); chk("R9 no strobe q0", mem_we, 1'b0);
    wr(8'h10, 32'h2222_2222); chk("R9 no strobe q1", mem_we, 1'b0);
    wr(8'h14, 32'h3333_3333); chk("R9 no strobe q2", mem_we, 1'b0);
    rd(8'h10, d); chk("R8 quarter readback", d, 32'h2222_2222);
    wr(8'h18, 32'h4444_4444);
    chk("R9 strobe", mem_we, 1'b1);
    chk("R9 addr", mem_addr, 12'h123);
    chk("R9 data", mem_data, {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111});
    @(negedge clk); chk("R9 strobe one cycle", mem_we, 1'b0);
    rd(8'h18, d); chk("R8 top readback", d, 32'h4444_4444);
  endtask

  task automatic t_tmode();
    seq_out = 32'hDEAD_BEEF;
    wr(8'h08, 32'h0000_0456);
    #1 chk("R10 normal follows seq", out, 32'hDEAD_BEEF);
    wr(8'h04, 32'h10);
    #1 chk("R10 mirror addr", out, 32'h0000_0456);
    wr(8'h04, 32'h0);
    #1 chk("R10 back to seq", out, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_scratch();
    t_readonly();
    t_csr();
    t_start();
    t_ext();
    t_stop();
    t_stage();
    t_tmode();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule